// File: doc/BRIEF.md
# DMA Address Translator with Page-Table Fetch

This block sits between a DMA engine and memory and turns the engine's virtual addresses into physical ones. It holds four translation entries. Each entry pairs a region tag, which covers a 4 MB slice of the virtual space, with a pointer to a page table held in memory. When an entry matches, the block reads one page-table word from memory and builds the physical address from that word and the page offset. Every translated access therefore costs one memory read.

A request enters through a valid/ready port together with a bypass flag. If bypass is set, the address comes back unchanged. If no entry matches, the response is zero. In both of these cases no memory access takes place and the answer is ready one cycle after the request is accepted. On a hit the block presents one read on its memory port and waits for the returned word. Only one translation is in flight at a time. Software loads the entries through a simple write port that selects an entry and either its tag word or its table word.

Top module: `dma_addr_xlate`

## Requirements
- R1: After reset `reqReady` is 1, and both `rspValid` and `memReqValid` are 0.
- R2: A cycle with `cfgWrEn`=1 writes `cfgWrData` into entry `cfgWrIdx` (0..3). It goes to the tag word when `cfgWrHigh`=1 and to the table word when `cfgWrHigh`=0. The write takes effect for any request accepted after that clock edge.
- R3: An entry matches when bits 31:22 of the request address equal bits 31:22 of its tag word. Bits 21:0 of the tag word are ignored. When several entries match, the lowest-numbered one is used.
- R4: On a hit the memory read address is ((table word AND 0x003FFFC0) << 6) + 4 × (request address bits 21:12).
- R5: On a hit the response address is ((returned word AND 0x03FFFFC0) << 6) + request address bits 11:0. `rspValid` rises in the cycle after the cycle in which `memRspValid` is seen.
- R6: On a miss (bypass 0, no match) the response address is 0. `rspValid` is 1 in the cycle after acceptance, and no memory read is issued.
- R7: With `reqBypass`=1 the response address equals the request address, even when an entry matches. It has the same one-cycle timing as R6 and issues no memory read.
- R8: `memReqValid` and `memReqAddr` hold until `memReqReady` is seen. `rspValid` and `rspAddr` hold until `rspReady` is seen.
- R9: `reqReady` is 1 only while no translation is in flight. It is 0 from acceptance until the response is taken, and it returns to 1 in the cycle after the response is taken.
- R10: `memRspValid` has no effect while no memory read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Translate request valid |
| reqReady | output | 1 | Block can accept a request |
| reqAddr | input | 32 | Virtual address |
| reqBypass | input | 1 | Return the address untranslated |
| rspValid | output | 1 | Response valid |
| rspReady | input | 1 | Engine accepts the response |
| rspAddr | output | 32 | Physical address (0 on miss) |
| memReqValid | output | 1 | Page-table read request |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | 32 | Page-table word address |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Page-table word |
| cfgWrEn | input | 1 | Entry write strobe |
| cfgWrIdx | input | 2 | Entry number |
| cfgWrHigh | input | 1 | 1 = tag word, 0 = table word |
| cfgWrData | input | 32 | Write data |

## Verification
The hardest case to reach is the priority rule. It only shows when two entries carry the same region tag in bits 31:22 but differ in their ignored low bits and in their table words. The stimulus loads entries 1 and 2 in exactly that way and then checks that the read address comes from entry 1. Backpressure on both the memory port and the response port is applied for several cycles to test the hold rules. A stray memory response is injected while the block is idle.

// File: rtl/dma_xlate_pkg.sv
`timescale 1ns/1ps
package dma_xlate_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } xlateState_t;

  typedef struct packed {
    logic capture;
    logic loadPte;
  } xlateStrobes_t;
endpackage

// File: rtl/xlate_entries.sv
`timescale 1ns/1ps
module xlate_entries #(
  parameter int NUM_ENTRIES = 4,
  parameter int ADDR_W      = 32,
  parameter int TAG_LSB     = 22,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [IDX_W-1:0]  cfgWrIdx,
  input  logic              cfgWrHigh,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic              lookupHit,
  output logic [ADDR_W-1:0] lookupLo
);
  logic [ADDR_W-1:0]      hiQ [NUM_ENTRIES];
  logic [ADDR_W-1:0]      loQ [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] matchVec;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : gEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hiQ[e] <= '0;
        loQ[e] <= '0;
      end else if (cfgWrEn && cfgWrIdx == IDX_W'(e)) begin
        if (cfgWrHigh) hiQ[e] <= cfgWrData;
        else           loQ[e] <= cfgWrData;
      end
    end
    assign matchVec[e] = hiQ[e][ADDR_W-1:TAG_LSB] == lookupAddr[ADDR_W-1:TAG_LSB];
  end

  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    lookupHit = |matchVec;
    lookupLo  = '0;
    for (int e = NUM_ENTRIES - 1; e >= 0; e--) begin
      if (matchVec[e]) lookupLo = loQ[e];
    end
  end
endmodule

// File: rtl/xlate_datapath.sv
`timescale 1ns/1ps
module xlate_datapath
  import dma_xlate_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter int              TAG_LSB  = 22,
  parameter int              PAGE_LSB = 12,
  parameter logic [ADDR_W-1:0] PT_MASK  = 32'h003F_FFC0,
  parameter logic [ADDR_W-1:0] PTE_MASK = 32'h03FF_FFC0,
  parameter int              FIELD_SH = 6,
  localparam int             IDX_W    = TAG_LSB - PAGE_LSB
) (
  input  logic              clk,
  input  logic              rstN,
  input  xlateStrobes_t     strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqBypass,
  input  logic              lookupHit,
  input  logic [ADDR_W-1:0] lookupLo,
  input  logic [ADDR_W-1:0] memRspData,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [ADDR_W-1:0] rspAddr
);
  logic [ADDR_W-1:0] vaddrQ, fetchQ, resultQ, fetchNext;
  logic [IDX_W-1:0]  pageIdx;
  logic              hitQ, bypassQ;

  assign pageIdx   = reqAddr[TAG_LSB-1:PAGE_LSB];
  assign fetchNext = ((lookupLo & PT_MASK) << FIELD_SH) + (ADDR_W'(pageIdx) << 2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaddrQ  <= '0;
      fetchQ  <= '0;
      resultQ <= '0;
      hitQ    <= 1'b0;
      bypassQ <= 1'b0;
    end else if (strobes.capture) begin
      vaddrQ  <= reqAddr;
      fetchQ  <= fetchNext;
      resultQ <= reqBypass ? reqAddr : '0;
      hitQ    <= lookupHit;
      bypassQ <= reqBypass;
    end else if (strobes.loadPte) begin
      resultQ <= ((memRspData & PTE_MASK) << FIELD_SH)
               + ADDR_W'(vaddrQ[PAGE_LSB-1:0]);
    end
  end

  assign memReqAddr = fetchQ;
  assign rspAddr    = resultQ;

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!hitQ && !bypassQ) |-> resultQ == '0);  // R6
  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rstN)
    bypassQ |-> resultQ == vaddrQ);  // R7
endmodule

// File: rtl/xlate_control.sv
`timescale 1ns/1ps
module xlate_control
  import dma_xlate_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          reqBypass,
  input  logic          lookupHit,
  input  logic          memReqReady,
  input  logic          memRspValid,
  input  logic          rspReady,
  output logic          reqReady,
  output logic          memReqValid,
  output logic          rspValid,
  output xlateStrobes_t strobes
);
  xlateState_t stateQ, stateNext;
  logic        accept;

  assign accept = reqValid && stateQ == ST_IDLE;

  always_comb begin
    stateNext = stateQ;
    unique case (stateQ)
      ST_IDLE:  if (reqValid) stateNext = (reqBypass || !lookupHit) ? ST_RESP : ST_FETCH;
      ST_FETCH: if (memReqReady) stateNext = ST_WAIT;
      ST_WAIT:  if (memRspValid) stateNext = ST_RESP;
      ST_RESP:  if (rspReady) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateNext;
  end

  assign reqReady        = stateQ == ST_IDLE;
  assign memReqValid     = stateQ == ST_FETCH;
  assign rspValid        = stateQ == ST_RESP;
  assign strobes.capture = accept;
  assign strobes.loadPte = stateQ == ST_WAIT && memRspValid;

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> memReqValid);  // R8
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> rspValid);  // R8
  AST_SINGLE_FLIGHT: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!memReqValid && !rspValid));  // R9
  AST_SHORT_PATH: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && (reqBypass || !lookupHit)) |=> (rspValid && !memReqValid));  // R6
  AST_STRAY_RSP: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && !reqValid && memRspValid) |=> reqReady);  // R10
endmodule

// File: rtl/dma_addr_xlate.sv
`timescale 1ns/1ps
module dma_addr_xlate
  import dma_xlate_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int ADDR_W      = 32,
  parameter int TAG_LSB     = 22,
  parameter int PAGE_LSB    = 12,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqBypass,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [ADDR_W-1:0] rspAddr,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memRspData,
  input  logic              cfgWrEn,
  input  logic [IDX_W-1:0]  cfgWrIdx,
  input  logic              cfgWrHigh,
  input  logic [ADDR_W-1:0] cfgWrData
);
  logic              lookupHit;
  logic [ADDR_W-1:0] lookupLo;
  xlateStrobes_t     strobes;

  xlate_entries #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W), .TAG_LSB(TAG_LSB)) uEntries (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgWrIdx(cfgWrIdx), .cfgWrHigh(cfgWrHigh), .cfgWrData(cfgWrData),
    .lookupAddr(reqAddr), .lookupHit(lookupHit), .lookupLo(lookupLo)
  );

  xlate_control uControl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqBypass(reqBypass), .lookupHit(lookupHit),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .rspReady(rspReady),
    .reqReady(reqReady), .memReqValid(memReqValid), .rspValid(rspValid),
    .strobes(strobes)
  );

  xlate_datapath #(.ADDR_W(ADDR_W), .TAG_LSB(TAG_LSB), .PAGE_LSB(PAGE_LSB)) uDatapath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .reqAddr(reqAddr), .reqBypass(reqBypass),
    .lookupHit(lookupHit), .lookupLo(lookupLo), .memRspData(memRspData),
    .memReqAddr(memReqAddr), .rspAddr(rspAddr)
  );

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> $stable(memReqAddr));  // R8
  AST_RSP_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> $stable(rspAddr));  // R8
endmodule

// File: tb/dma_addr_xlate_test.sv
`timescale 1ns/1ps
module dma_addr_xlate_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqBypass = 1'b0, rspReady = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        memReqReady = 1'b0, memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        cfgWrEn = 1'b0, cfgWrHigh = 1'b0;
  logic [1:0]  cfgWrIdx = '0;
  logic [31:0] cfgWrData = '0;
  logic        reqReady, rspValid, memReqValid;
  logic [31:0] rspAddr, memReqAddr;

  int errors = 0;
  int checks = 0;
  logic [31:0] mHi [4];
  logic [31:0] mLo [4];

  always #2.5 clk = ~clk;

  dma_addr_xlate uut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr), .reqBypass(reqBypass),
    .rspValid(rspValid), .rspReady(rspReady), .rspAddr(rspAddr),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .cfgWrEn(cfgWrEn), .cfgWrIdx(cfgWrIdx), .cfgWrHigh(cfgWrHigh), .cfgWrData(cfgWrData)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic logic [31:0] pteFor(input logic [31:0] a);
    return a * 32'd2654435761 + 32'h1357_9BDF;
  endfunction

  // behavioural reference: scan all entries, the lowest match wins
  function automatic void refModel(input logic [31:0] va, input bit byp,
                                   output bit needMem, output logic [31:0] fetchA,
                                   output logic [31:0] direct);
    needMem = 0;
    fetchA  = '0;
    direct  = byp ? va : 32'h0;
    if (!byp) begin
      for (int e = 3; e >= 0; e--) begin
        if ((va >> 22) == (mHi[e] >> 22)) begin
          needMem = 1;
          fetchA  = ((mLo[e] & 32'h003F_FFC0) << 6) + ((va >> 12) & 32'h3FF) * 4;
        end
      end
    end
  endfunction

  task automatic cfgWrite(input int idx, input bit hi, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrIdx = idx[1:0]; cfgWrHigh = hi; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (hi) mHi[idx] = d; else mLo[idx] = d;
  endtask

  task automatic xlate(input logic [31:0] va, input bit byp, input int rdyDelay,
                       input int memLat, input int rspDelay);
    bit          needMem;
    logic [31:0] fetchA, direct, expA;
    string       tag;
    refModel(va, byp, needMem, fetchA, direct);
    tag = needMem ? "R5 physical" : (byp ? "R7 bypass" : "R6 miss");
    @(negedge clk);
    chk(reqReady, "R9 ready when idle", {31'b0, reqReady}, 32'd1);
    reqValid = 1'b1; reqAddr = va; reqBypass = byp;
    @(negedge clk);
    reqValid = 1'b0;
    chk(!reqReady, "R9 busy after accept", {31'b0, reqReady}, 32'd0);
    if (needMem) begin
      for (int i = 0; i < rdyDelay; i++) begin
        chk(memReqValid, "R8 read held", {31'b0, memReqValid}, 32'd1);
        chk(memReqAddr == fetchA, "R4 read address held", memReqAddr, fetchA);
        @(negedge clk);
      end
      chk(memReqValid, "R4 read issued", {31'b0, memReqValid}, 32'd1);
      chk(memReqAddr == fetchA, "R4 read address", memReqAddr, fetchA);
      memReqReady = 1'b1;
      @(negedge clk);
      memReqReady = 1'b0;
      chk(!memReqValid, "R8 read dropped after accept", {31'b0, memReqValid}, 32'd0);
      for (int i = 0; i < memLat; i++) begin
        chk(!rspValid, "R5 no early response", {31'b0, rspValid}, 32'd0);
        @(negedge clk);
      end
      memRspValid = 1'b1; memRspData = pteFor(fetchA);
      @(negedge clk);
      memRspValid = 1'b0;
      expA = ((pteFor(fetchA) & 32'h03FF_FFC0) << 6) + (va & 32'hFFF);
    end else begin
      chk(!memReqValid, "R6 R7 no memory read", {31'b0, memReqValid}, 32'd0);
      expA = direct;
    end
    for (int i = 0; i < rspDelay; i++) begin
      chk(rspValid, "R8 response held", {31'b0, rspValid}, 32'd1);
      chk(rspAddr == expA, "R8 response address held", rspAddr, expA);
      @(negedge clk);
    end
    chk(rspValid, tag, {31'b0, rspValid}, 32'd1);
    chk(rspAddr == expA, tag, rspAddr, expA);
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
    chk(!rspValid && reqReady, "R9 idle after response", {30'b0, rspValid, reqReady}, 32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    for (int e = 0; e < 4; e++) begin mHi[e] = '0; mLo[e] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(reqReady, "R1 reqReady in reset", {31'b0, reqReady}, 32'd1);
    chk(!rspValid && !memReqValid, "R1 outputs low in reset", {30'b0, rspValid, memReqValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !rspValid && !memReqValid, "R1 state after reset",
        {29'b0, reqReady, rspValid, memReqValid}, 32'd4);

    // R2 load entries; entries 1 and 2 share one region (R3 priority)
    cfgWrite(0, 1, 32'h0040_0000); cfgWrite(0, 0, 32'h0001_2340);
    cfgWrite(1, 1, 32'h80C0_0ABC); cfgWrite(1, 0, 32'h001F_FFC0);
    cfgWrite(2, 1, 32'h80F3_FFFF); cfgWrite(2, 0, 32'h0030_0000);
    cfgWrite(3, 1, 32'hFFC0_0000); cfgWrite(3, 0, 32'hFFFF_FFFF);

    xlate(32'h0045_6789, 0, 0, 0, 0);  // R4 R5 entry 0
    xlate(32'h80FF_F123, 0, 2, 3, 2);  // R3 entries 1 and 2 both match, 1 wins
    xlate(32'hFFFF_FFFF, 0, 1, 0, 1);  // R4 masking of table word, top region
    xlate(32'h1234_5678, 0, 0, 0, 2);  // R6 miss
    xlate(32'h0045_6789, 1, 0, 0, 1);  // R7 bypass despite a match
    xlate(32'hDEAD_BEEF, 1, 0, 0, 0);  // R7 bypass, no match

    // R10 stray memory response while idle
    @(negedge clk);
    memRspValid = 1'b1; memRspData = 32'hFFFF_FFFF;
    @(negedge clk);
    memRspValid = 1'b0;
    chk(!rspValid && reqReady, "R10 stray response ignored", {30'b0, rspValid, reqReady}, 32'd1);

    // R2 rewrite table word of entry 0, later request uses it
    cfgWrite(0, 0, 32'h0000_0FC0);
    xlate(32'h007F_F001, 0, 0, 1, 0);
    // R2 retag entry 2 so it now owns a new region
    cfgWrite(2, 1, 32'h4000_0000);
    xlate(32'h4000_3ABC, 0, 1, 1, 0);
    summary();
  end
endmodule